// File: doc/BRIEF.md
# Integer Minimum/Maximum Unit with Condition Field

This unit picks the smaller or the larger of two integer register operands and can also report how the two operands compared, as a 4-bit condition field. A 3-bit mode sets three things: whether the comparison uses the full doubleword or only the low word, whether it is signed or unsigned, and whether the unit returns the minimum or the maximum. A separate flag makes the first operand the constant zero. This is the case where the first register specifier names register zero. Both operands then go through one shared unsigned comparator.

The comparison works on operands that have been narrowed and sign-adjusted, but the value returned is always one of the full, unmodified sources. In word mode the upper halves of the sources therefore pass through to the result. The unit has one register stage: it samples its inputs on a rising clock edge, and the result and condition field appear after that edge.

Top module: `int_minmax_cc`

## Requirements
- R1: Mode encoding is as follows: `mode[0]`=1 selects a word (low half) comparison and 0 a doubleword comparison; `mode[1]`=1 selects signed and 0 unsigned; `mode[2]`=1 selects maximum and 0 minimum. An unsigned doubleword minimum returns the operand with the smaller unsigned value, and the maximum returns the operand with the larger one.
- R2: A signed comparison orders the operands as two's-complement numbers of the selected width.
- R3: In word mode only the low WIDTH/2 bits of each operand take part in the comparison. The upper bits have no effect on which operand is chosen or on the condition field.
- R4: The result is always the full WIDTH-bit selected source, even in word mode. That source is either the first operand (or zero) or the second operand.
- R5: When `a_is_zero` is 1, the first operand is the constant 0 in both the comparison and the result, and `src_a` is ignored.
- R6: When the adjusted operands compare equal, the result is the second operand, in both minimum and maximum modes.
- R7: When `rec` is 1, `cc_we` is 1 and `cc` = {lt, gt, eq, `so`}, with bit 3 = lt, bit 2 = gt, bit 1 = eq and bit 0 = `so`. The flags compare the first adjusted operand against the second in their original order, in maximum mode as well.
- R8: When `rec` is 0, `cc_we` is 0 and `cc` is 0000.
- R9: Outputs update one clock after the inputs are sampled. While `rst_n` is low (synchronous, active low), `result`, `cc` and `cc_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | WIDTH | First register operand |
| src_b | input | WIDTH | Second register operand |
| a_is_zero | input | 1 | Use constant 0 in place of the first operand |
| mode | input | 3 | Width / signedness / direction mode |
| rec | input | 1 | Record bit, requests the condition field |
| so | input | 1 | Summary-overflow bit copied into the condition field |
| result | output | WIDTH | Selected full-width source |
| cc | output | 4 | Condition field {lt, gt, eq, so} |
| cc_we | output | 1 | Condition field write enable |

## Verification
The hardest cases to reach are word-mode pairs whose upper halves order the other way from their lower halves, and pairs whose low words differ only in sign. These expose any comparator that looks at the wrong half, and any result path that truncates or rebuilds the value instead of passing the source through. The operand set is chosen for this: it pairs values whose upper and lower halves disagree in sign and magnitude. Every ordered pair is then swept through all eight modes, both record settings and both zero-flag settings. The expected values come from a model that sign- or zero-extends each operand, rather than shifting it.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
    localparam int MODE_W    = 3;
    localparam int MODE_WORD = 0;
    localparam int MODE_SGN  = 1;
    localparam int MODE_MAX  = 2;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cc_t;
endpackage

// File: rtl/mmx_prep.sv
module mmx_prep #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             word,
    input  logic             sgn,
    output logic [WIDTH-1:0] adj
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] placed;

    always_comb begin
        // word mode: low half moved to the top so one comparator serves both widths
        placed = word ? {raw[HALF-1:0], {HALF{1'b0}}} : raw;
        // flipping the top bit turns a signed order into an unsigned one
        adj    = {placed[WIDTH-1] ^ sgn, placed[WIDTH-2:0]};
    end
endmodule

// File: rtl/mmx_cmp.sv
module mmx_cmp #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             lt,
    output logic             gt,
    output logic             eq
);
    always_comb begin
        lt = lhs < rhs;
        eq = lhs == rhs;
        gt = !lt && !eq;
    end

    always_comb begin
        assert ($countones({lt, gt, eq}) == 1);
    end
endmodule

// File: rtl/int_minmax_cc.sv
module int_minmax_cc
    import mmx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  src_a,
    input  logic [WIDTH-1:0]  src_b,
    input  logic              a_is_zero,
    input  logic [MODE_W-1:0] mode,
    input  logic              rec,
    input  logic              so,
    output logic [WIDTH-1:0]  result,
    output logic [3:0]        cc,
    output logic              cc_we
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        cc_t              cc;
        logic             cc_we;
    } out_t;

    out_t out_d, out_q;

    logic [WIDTH-1:0] eff_a;
    logic [WIDTH-1:0] raw_op [NOPS];
    logic [WIDTH-1:0] adj_op [NOPS];
    logic             cmp_lt, cmp_gt, cmp_eq;
    logic             pick_a;
    logic             hist_q;

    assign eff_a     = a_is_zero ? '0 : src_a;
    assign raw_op[0] = eff_a;
    assign raw_op[1] = src_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_prep
        mmx_prep #(.WIDTH(WIDTH)) u_prep (
            .raw  (raw_op[g]),
            .word (mode[MODE_WORD]),
            .sgn  (mode[MODE_SGN]),
            .adj  (adj_op[g])
        );
    end

    mmx_cmp #(.WIDTH(WIDTH)) u_cmp (
        .lhs (adj_op[0]),
        .rhs (adj_op[1]),
        .lt  (cmp_lt),
        .gt  (cmp_gt),
        .eq  (cmp_eq)
    );

    always_comb begin
        // maximum swaps the less-than operands: b<a is the gt flag
        pick_a = mode[MODE_MAX] ? cmp_gt : cmp_lt;

        out_d        = '0;
        out_d.result = pick_a ? eff_a : src_b;
        out_d.cc_we  = rec;
        if (rec) begin
            out_d.cc.lt = cmp_lt;
            out_d.cc.gt = cmp_gt;
            out_d.cc.eq = cmp_eq;
            out_d.cc.so = so;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            hist_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            hist_q <= 1'b1;
        end
    end

    assign result = out_q.result;
    assign cc     = out_q.cc;
    assign cc_we  = out_q.cc_we;

    AST_CC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |-> cc == 4'b0000); // R8
    AST_CC_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> $countones(cc[3:1]) == 1); // R7
    AST_WE_FOLLOWS_REC: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q |-> cc_we == $past(rec)); // R9
    AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q && cc_we) |-> cc[0] == $past(so)); // R7
    AST_RESULT_IS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_q |-> (result == $past(src_b) ||
                    result == ($past(a_is_zero) ? '0 : $past(src_a)))); // R4
    AST_EQ_PICKS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q && cc_we && cc[1]) |-> result == $past(src_b)); // R6
endmodule

// File: tb/int_minmax_cc_test.sv
module int_minmax_cc_test;
    localparam int W = 64;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0;
    logic         a_is_zero = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         rec = 1'b0, so = 1'b0;
    logic [W-1:0] result;
    logic [3:0]   cc;
    logic         cc_we;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    int_minmax_cc #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .a_is_zero(a_is_zero), .mode(mode), .rec(rec), .so(so),
        .result(result), .cc(cc), .cc_we(cc_we)
    );

    logic [W-1:0] vals [NV];

    initial begin
        vals[0]  = 64'h0000_0000_0000_0000;
        vals[1]  = 64'h0000_0000_0000_0001;
        vals[2]  = 64'h0000_0000_0000_0002;
        vals[3]  = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[4]  = 64'h8000_0000_0000_0000;
        vals[5]  = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[6]  = 64'h0000_0000_8000_0000;
        vals[7]  = 64'h0000_0000_7FFF_FFFF;
        vals[8]  = 64'hFFFF_FFFF_0000_0001;
        vals[9]  = 64'h1234_5678_0000_0001;
        vals[10] = 64'h8000_0000_FFFF_FFFE;
        vals[11] = 64'h0000_0001_0000_0000;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic z, input logic [2:0] m, input logic r,
                         input logic s, output logic [W-1:0] res,
                         output logic [3:0] c, output logic we);
        logic [W-1:0] av, x, y;
        logic lt, gt, eq, sg;
        av = z ? '0 : a;
        sg = m[1];
        if (m[0]) begin
            x = {{32{sg & av[31]}}, av[31:0]};
            y = {{32{sg & b[31]}}, b[31:0]};
        end else begin
            x = av;
            y = b;
        end
        lt = sg ? ($signed(x) < $signed(y)) : (x < y);
        eq = (x == y);
        gt = !lt && !eq;
        res = (m[2] ? gt : lt) ? av : b;
        we = r;
        c = r ? {lt, gt, eq, s} : 4'b0000;
    endtask

    initial begin
        logic [W-1:0] er;
        logic [3:0]   ec;
        logic         ew;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(result == '0 && cc == 4'b0 && cc_we == 1'b0, "R9 reset",
              {result[59:0], cc}, '0);
        // R9: still zero while held in reset with live inputs
        src_a = 64'hDEAD; src_b = 64'hBEEF; rec = 1'b1;
        @(negedge clk);
        check(result == '0 && cc_we == 1'b0, "R9 held reset", result, '0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < NV; j++) begin
                for (int m = 0; m < 8; m++) begin
                    for (int k = 0; k < 4; k++) begin
                        src_a = vals[i]; src_b = vals[j];
                        mode = 3'(m); rec = k[0]; a_is_zero = k[1];
                        so = 1'((i + j + m) & 1);
                        model(src_a, src_b, a_is_zero, mode, rec, so, er, ec, ew);
                        @(posedge clk);
                        @(negedge clk);
                        // R1 R2 R3 R4 R5 R6: selected full-width source
                        check(result == er, "R1 R2 R3 R4 R5 R6 result", result, er);
                        if (rec)
                            check(cc == ec && cc_we == 1'b1, "R7 cc", {cc_we, cc}, {ew, ec});
                        else
                            check(cc == 4'b0 && cc_we == 1'b0, "R8 cc off", {cc_we, cc}, {ew, ec});
                    end
                end
            end
        end
        // R9: one-cycle latency, output holds the previous sample before the edge
        src_a = 64'h5; src_b = 64'h9; mode = 3'b000; a_is_zero = 1'b0; rec = 1'b0;
        @(posedge clk); @(negedge clk);
        src_a = 64'hA; src_b = 64'h3;
        #1;
        check(result == 64'h5, "R9 latency hold", result, 64'h5);
        @(posedge clk); @(negedge clk);
        check(result == 64'h3, "R9 latency update", result, 64'h3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule